// File: doc/BRIEF.md
# Streaming Pixel Offset, Gain and Defect Corrector

This block sits directly after the digitizers of an imaging panel and cleans each pixel as it streams past in raster order. Every pixel first has its own dark level removed. The remainder is then scaled by its own flat-field sensitivity factor. A pixel that is flagged as defective has its value rebuilt from the nearest usable pixels on its left and right in the same line. The corrected stream leaves the block with the same frame and line markers as the input, a fixed number of cycles later.

The three per-pixel tables are held in on-chip storage. They are filled through a small write port that selects the table and gives a flat pixel address. A bypass input sends raw pixels through the same pipeline with their values unchanged, so that downstream logic keeps receiving frames while the tables are being rewritten. Lines are expected to arrive with their pixels on back-to-back cycles. Idle cycles are allowed only between lines.

Top module: `pxc_corrector`

## Requirements
- R1: A table write with `wr_en` high stores `wr_data` at flat address `row*COLS+col` in the table chosen by `wr_sel`. Code 0 selects the dark offset (low 12 bits), code 1 selects the gain (16 bits) and code 2 selects the defect flag (bit 0).
- R2: The dark offset is subtracted from the 12-bit raw pixel, and a negative difference becomes zero.
- R3: The difference is multiplied by the gain, an unsigned fixed-point value in which 16384 means 1.0. The product gets 8192 added and is shifted right by 14. A result above 4095 saturates to 4095.
- R4: A pixel with `in_sof` high is at row 0, column 0. Each following pixel advances the column, and a pixel with `in_eol` high ends its row, so the next pixel is at column 0 of the next row.
- R5: A flagged pixel inside a line is replaced by (L+R+1)>>1. L and R are the corrected values of the nearest unflagged pixels on each side, searching at most two positions away. This means a pair of adjacent flagged pixels both use the pixels just outside the pair.
- R6: A flagged pixel at the first or last column takes the corrected value of its single usable neighbour in the same line. No pixel from a neighbouring line is ever used.
- R7: Every output appears exactly 5 cycles after its input. The outputs `out_sof` and `out_eol` stay attached to the same pixels as on the input.
- R8: While `bypass` is high when a pixel enters, that pixel leaves with its raw value, with the same latency and markers.
- R9: During and right after reset, `out_valid`, `out_sof` and `out_eol` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Pass raw pixels unchanged |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: 0 offset, 1 gain, 2 defect flag |
| wr_addr | input | clog2(COLS*ROWS) | Flat pixel address of the write |
| wr_data | input | 16 | Value to store |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_data | input | 12 | Raw pixel value |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | First pixel of a frame |
| out_eol | output | 1 | Last pixel of a line |
| out_data | output | 12 | Corrected pixel value |

## Verification
The bench loads every table entry and sweeps whole frames. These frames hold flagged pixels at both line edges, an adjacent flagged pair and a lone flagged pixel inside a line. An edge handled wrongly would pull a value from the previous or next line, or average with zero. A pair handled wrongly would average a flagged neighbour into the result. One frame is built so that most offsets exceed the pixel value, and large gains drive other pixels to the ceiling. Missing clamping would show as wrapped, huge values, and missing saturation would show as truncated low bits. A bypassed frame and a cycle-exact latency measurement catch markers that slip against their pixels, and raw data that is still corrected.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    localparam int PIX_W     = 12;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 14;
    localparam int WR_W      = 16;
    localparam int LATENCY   = 5;

    typedef enum logic [1:0] {
        TBL_OFFSET = 2'd0,
        TBL_GAIN   = 2'd1,
        TBL_DEFECT = 2'd2
    } tbl_sel_e;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [GAIN_W-1:0] gain_t;

    // pixel metadata after position tracking
    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
        logic sol;
        logic byp;
        pix_t raw;
    } meta_t;

    // pixel after arithmetic correction
    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
        logic sol;
        logic byp;
        logic def;
        pix_t raw;
        pix_t val;
    } tap_t;

    function automatic pix_t scale_pixel(pix_t d, pix_t o, gain_t g);
        pix_t                          diff;
        logic [PIX_W+GAIN_W-1:0]       prod;
        logic [PIX_W+GAIN_W:0]         sum;
        logic [PIX_W+GAIN_W-GAIN_FRAC:0] q;
        diff = (d > o) ? pix_t'(d - o) : '0;
        prod = diff * g;
        sum  = {1'b0, prod} + (PIX_W+GAIN_W+1)'(1 << (GAIN_FRAC-1));
        q    = sum[PIX_W+GAIN_W:GAIN_FRAC];
        if (|q[$bits(q)-1:PIX_W])
            return '1;
        return q[PIX_W-1:0];
    endfunction

    function automatic pix_t mean_up(pix_t a, pix_t b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
        return s[PIX_W:1];
    endfunction
endpackage

// File: rtl/pxc_locator.sv
module pxc_locator
    import pxc_pkg::*;
#(
    parameter int COLS = 16,
    parameter int ROWS = 8,
    parameter int AW   = $clog2(COLS*ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  pix_t          in_data,
    input  logic          bypass,
    output logic [AW-1:0] rd_addr,
    output meta_t         meta_q
);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [CW-1:0] col_q, cur_col;
    logic [RW-1:0] row_q, cur_row;

    always_comb begin
        cur_col = in_sof ? '0 : col_q;
        cur_row = in_sof ? '0 : row_q;
        rd_addr = AW'(cur_row) * AW'(COLS) + AW'(cur_col);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            row_q  <= '0;
            meta_q <= '0;
        end else begin
            meta_q.valid <= in_valid;
            meta_q.sof   <= in_valid & in_sof;
            meta_q.eol   <= in_valid & in_eol;
            meta_q.sol   <= (cur_col == '0);
            meta_q.byp   <= bypass;
            meta_q.raw   <= in_data;
            if (in_valid) begin
                if (in_eol) begin
                    col_q <= '0;
                    row_q <= (cur_row == RW'(ROWS-1)) ? '0 : cur_row + RW'(1);
                end else begin
                    col_q <= cur_col + CW'(1);
                end
            end
        end
    end

    // R4: a frame start always lands at the first table entry
    assert_sof_origin_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sof |-> rd_addr == '0);
endmodule

// File: rtl/pxc_tables.sv
module pxc_tables
    import pxc_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output pix_t            off_q,
    output gain_t           gain_q,
    output logic            def_q
);
    pix_t  off_mem  [DEPTH];
    gain_t gain_mem [DEPTH];
    logic  def_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            unique case (tbl_sel_e'(wr_sel))
                TBL_OFFSET: off_mem[wr_addr]  <= wr_data[PIX_W-1:0];
                TBL_GAIN:   gain_mem[wr_addr] <= wr_data[GAIN_W-1:0];
                TBL_DEFECT: def_mem[wr_addr]  <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            gain_q <= '0;
            def_q  <= 1'b0;
        end else begin
            off_q  <= off_mem[rd_addr];
            gain_q <= gain_mem[rd_addr];
            def_q  <= def_mem[rd_addr];
        end
    end

    // R1: a stored offset is readable at its address one cycle later
    assert_offset_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == 2'd0 |=> off_mem[$past(wr_addr)] == $past(wr_data[PIX_W-1:0]));
    assert_gain_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == 2'd1 |=> gain_mem[$past(wr_addr)] == $past(wr_data[GAIN_W-1:0]));
endmodule

// File: rtl/pxc_scaler.sv
module pxc_scaler
    import pxc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  meta_t meta,
    input  pix_t  off,
    input  gain_t gain,
    input  logic  def,
    output tap_t  px_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            px_q <= '0;
        end else begin
            px_q.valid <= meta.valid;
            px_q.sof   <= meta.sof;
            px_q.eol   <= meta.eol;
            px_q.sol   <= meta.sol;
            px_q.byp   <= meta.byp;
            px_q.def   <= meta.valid & def;
            px_q.raw   <= meta.raw;
            px_q.val   <= scale_pixel(meta.raw, off, gain);
        end
    end

    // R2: a pixel at or below its dark level corrects to zero
    assert_dark_clamp_R2: assert property (@(posedge clk) disable iff (rst)
        meta.valid && (meta.raw <= off) |=> px_q.val == '0);
endmodule

// File: rtl/pxc_defect_fill.sv
module pxc_defect_fill
    import pxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  tap_t px_in,
    output logic out_valid,
    output logic out_sof,
    output logic out_eol,
    output pix_t out_data
);
    localparam int TAPS   = 5;
    localparam int CENTER = 2;

    tap_t taps [1:TAPS-1];
    tap_t w    [0:TAPS-1];
    tap_t c;
    logic l1_ok, l2_ok, r1_ok, r2_ok;
    logic have_l, have_r;
    pix_t l_val, r_val, fill;

    always_comb begin
        w[0] = px_in;
        for (int k = 1; k < TAPS; k++) w[k] = taps[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < TAPS; k++) taps[k] <= '0;
        end else begin
            taps[1] <= px_in;
            for (int k = 2; k < TAPS; k++) taps[k] <= taps[k-1];
        end
    end

    always_comb begin
        c     = w[CENTER];
        l1_ok = w[CENTER+1].valid && !c.sol;
        l2_ok = l1_ok && w[CENTER+2].valid && !w[CENTER+1].sol;
        r1_ok = w[CENTER-1].valid && !c.eol;
        r2_ok = r1_ok && w[CENTER-2].valid && !w[CENTER-1].eol;

        have_l = 1'b0;
        l_val  = '0;
        if (l1_ok && !w[CENTER+1].def) begin
            have_l = 1'b1;
            l_val  = w[CENTER+1].val;
        end else if (l2_ok && !w[CENTER+2].def) begin
            have_l = 1'b1;
            l_val  = w[CENTER+2].val;
        end

        have_r = 1'b0;
        r_val  = '0;
        if (r1_ok && !w[CENTER-1].def) begin
            have_r = 1'b1;
            r_val  = w[CENTER-1].val;
        end else if (r2_ok && !w[CENTER-2].def) begin
            have_r = 1'b1;
            r_val  = w[CENTER-2].val;
        end

        if (have_l && have_r) fill = mean_up(l_val, r_val);
        else if (have_l)      fill = l_val;
        else if (have_r)      fill = r_val;
        else                  fill = c.val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= c.valid;
            out_sof   <= c.sof;
            out_eol   <= c.eol;
            if (c.byp)      out_data <= c.raw;
            else if (c.def) out_data <= fill;
            else            out_data <= c.val;
        end
    end

    // R7: a pixel reaching the centre tap leaves on the next cycle
    assert_center_release_R7: assert property (@(posedge clk) disable iff (rst)
        c.valid |=> out_valid);
    // R8: bypassed pixels carry their raw value out
    assert_bypass_raw_R8: assert property (@(posedge clk) disable iff (rst)
        c.valid && c.byp |=> out_data == $past(c.raw));
endmodule

// File: rtl/pxc_corrector.sv
module pxc_corrector
    import pxc_pkg::*;
#(
    parameter int COLS = 16,
    parameter int ROWS = 8,
    localparam int DEPTH = COLS * ROWS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [PIX_W-1:0]  in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eol,
    output logic [PIX_W-1:0]  out_data
);
    logic [AW-1:0] rd_addr;
    meta_t         meta_q;
    pix_t          off_q;
    gain_t         gain_q;
    logic          def_q;
    tap_t          px_q;

    pxc_locator #(.COLS(COLS), .ROWS(ROWS), .AW(AW)) u_locator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_data(in_data), .bypass(bypass),
        .rd_addr(rd_addr), .meta_q(meta_q)
    );

    pxc_tables #(.DEPTH(DEPTH), .AW(AW)) u_tables (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .off_q(off_q), .gain_q(gain_q), .def_q(def_q)
    );

    pxc_scaler u_scaler (
        .clk(clk), .rst(rst), .meta(meta_q), .off(off_q),
        .gain(gain_q), .def(def_q), .px_q(px_q)
    );

    pxc_defect_fill u_fill (
        .clk(clk), .rst(rst), .px_in(px_q), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
    );

    // cycles since reset, saturating, so $past never reaches into reset
    logic [3:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst != 4'd8) since_rst <= since_rst + 4'd1;
    end

    assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (rst)
        since_rst >= 4'd7 |-> out_valid == $past(in_valid, 5));
    assert_sof_align_R7: assert property (@(posedge clk) disable iff (rst)
        since_rst >= 4'd7 |-> out_sof == $past(in_valid && in_sof, 5));
    assert_eol_align_R7: assert property (@(posedge clk) disable iff (rst)
        since_rst >= 4'd7 |-> out_eol == $past(in_valid && in_eol, 5));
    assert_quiet_after_reset_R9: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !out_sof && !out_eol);
endmodule

// File: tb/pxc_corrector_test.sv
module pxc_corrector_test;
    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam int NPIX = COLS * ROWS;
    localparam int AW   = $clog2(NPIX);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bypass = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [11:0] in_data = '0;
    logic out_valid, out_sof, out_eol;
    logic [11:0] out_data;

    always #10 clk = ~clk;

    pxc_corrector #(.COLS(COLS), .ROWS(ROWS)) uut (
        .clk(clk), .rst(rst), .bypass(bypass), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .in_valid(in_valid),
        .in_sof(in_sof), .in_eol(in_eol), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
        .out_data(out_data)
    );

    int tests = 0, fails = 0;
    int pe = 0;
    int cap_n = 0;
    int cap_val [NPIX];
    bit cap_sof [NPIX];
    bit cap_eol [NPIX];
    int first_in_pe = -1, first_out_pe = -1;
    bit done = 0;

    int offs [NPIX];
    int gains [NPIX];
    bit defs [NPIX];

    always @(posedge clk) begin
        pe <= pe + 1;
        if (pe > 100000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (out_valid && cap_n < NPIX) begin
            if (cap_n == 0) first_out_pe = pe;
            cap_val[cap_n] = int'(out_data);
            cap_sof[cap_n] = out_sof;
            cap_eol[cap_n] = out_eol;
            cap_n++;
        end
    end

    task automatic check(string req, int actual, int expected, string what);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic write_tbl(int sel, int addr, int data);
        wr_en   = 1'b1;
        wr_sel  = 2'(sel);
        wr_addr = AW'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int pat(int p, int a);
        if (p == 0) return (a * 523 + 300) % 4096;
        return (a * 7) % 60;
    endfunction

    function automatic int corr(int d, int o, int g);
        int diff, r;
        diff = (d > o) ? d - o : 0;
        r = (diff * g + 8192) >>> 14;
        return (r > 4095) ? 4095 : r;
    endfunction

    task automatic send_frame(int p, bit byp);
        cap_n = 0;
        first_out_pe = -1;
        bypass = byp;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (r == 0 && c == 0) first_in_pe = pe;
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_eol   = (c == COLS-1);
                in_data  = 12'(pat(p, r*COLS + c));
                @(negedge clk);
            end
            in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic check_frame(int p, bit byp);
        int cv [NPIX];
        for (int a = 0; a < NPIX; a++) cv[a] = corr(pat(p, a), offs[a], gains[a]);
        check("R7", cap_n, NPIX, "output pixel count");
        check("R7", first_out_pe - first_in_pe, 5, "latency in cycles");
        for (int a = 0; a < NPIX; a++) begin
            int c, exp, lv, rv;
            bit hl, hr;
            string req;
            c = a % COLS;
            if (byp) begin
                exp = pat(p, a); req = "R8";
            end else if (!defs[a]) begin
                exp = cv[a];
                req = (pat(p, a) <= offs[a]) ? "R2" : "R3";
            end else begin
                hl = 0; hr = 0; lv = 0; rv = 0;
                if (c >= 1 && !defs[a-1]) begin hl = 1; lv = cv[a-1]; end
                else if (c >= 2 && !defs[a-2]) begin hl = 1; lv = cv[a-2]; end
                if (c <= COLS-2 && !defs[a+1]) begin hr = 1; rv = cv[a+1]; end
                else if (c <= COLS-3 && !defs[a+2]) begin hr = 1; rv = cv[a+2]; end
                if (hl && hr) exp = (lv + rv + 1) >>> 1;
                else if (hl) exp = lv;
                else if (hr) exp = rv;
                else exp = cv[a];
                req = (c == 0 || c == COLS-1) ? "R6" : "R5";
            end
            if (a < cap_n) begin
                check(req, cap_val[a], exp, $sformatf("pixel %0d value", a));
                check("R4", int'(cap_sof[a]), int'(a == 0), $sformatf("pixel %0d sof", a));
                check("R7", int'(cap_eol[a]), int'(c == COLS-1), $sformatf("pixel %0d eol", a));
            end
        end
    endtask

    initial begin
        for (int a = 0; a < NPIX; a++) begin
            offs[a]  = (a * 29) % 150;
            gains[a] = 8192 + (a * 1999) % 57000;
            defs[a]  = (a == 0 || a == 15 || a == 19 || a == 20 || a == 29);
        end
        repeat (3) @(negedge clk);
        check("R9", int'(out_valid), 0, "valid in reset");
        check("R9", int'(out_sof), 0, "sof in reset");
        check("R9", int'(out_eol), 0, "eol in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R9", int'(out_valid), 0, "valid after reset");
        bypass = 1'b1;
        // R1: fill all three tables through the write port
        for (int a = 0; a < NPIX; a++) begin
            write_tbl(0, a, offs[a]);
            write_tbl(1, a, gains[a]);
            write_tbl(2, a, int'(defs[a]));
        end
        send_frame(0, 1'b0);
        check_frame(0, 1'b0);
        send_frame(1, 1'b0);
        check_frame(1, 1'b0);
        send_frame(0, 1'b1);
        check_frame(0, 1'b1);
        // R1: rewrite one gain to unity and the defect flag of pixel 29 off
        gains[29] = 16384; defs[29] = 0;
        write_tbl(1, 29, 16384);
        write_tbl(2, 29, 0);
        send_frame(0, 1'b0);
        check_frame(0, 1'b0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule